// File: doc/BRIEF.md
# Link Speed-Up Controller

This controller brings a serial link up at the lowest rate, then optionally moves it to the second-generation rate. On a start request it clamps the link-speed cap field to Gen1 and only then enables the training state machine of the link core. That way, downstream devices behind switches are found reliably. Once the link reports up and idle, a Gen1-only configuration finishes at once. A Gen2 configuration raises the cap to 2 and pulses a directed speed-change request.

In the normal variant, the controller polls the core's speed-change-pending flag at a fixed interval until the flag clears. If it is still set after a bounded number of polls, the controller fails. In the other variant, selected by a strap input, it skips that wait, because some cores leave the flag set when the rate stays at Gen1. In both variants, the link must report up again before success. The negotiated generation is then latched from the core's current-rate field.

Every wait for link-up is bounded by a cycle timeout. Any failure drops the training enable, raises a sticky fail flag and issues a fixed-length receive-reset request to the PHY.

Top module: `link_speedup_ctrl`

## Requirements
- R1: After reset, max_speed is 1, final_gen is 0, and ltssm_en, chg_req, done, fail and phy_rx_reset_req are all 0.
- R2: A start accepted at a clock edge forces max_speed to 1 and ltssm_en to 0 at that edge. ltssm_en rises at the next edge, so the cap is already 1 for a full cycle before training is enabled.
- R3: The link counts as up only when link_up is 1 and link_training is 0. With cfg_gen2 at 0, the first link-up sets done with final_gen equal to cur_gen. max_speed stays 1 and chg_req never pulses.
- R4: With cfg_gen2 at 1, the first link-up sets max_speed to 2 and produces exactly one chg_req pulse one cycle wide.
- R5: With cfg_no_chg_wait at 0, chg_pending is sampled once every POLL_GAP cycles. If it is still 1 on the POLL_LIMIT-th sample, the controller fails.
- R6: With cfg_no_chg_wait at 1, chg_pending is not consulted. A link that stays up completes with done even if chg_pending never clears.
- R7: After the speed change, done is reported only when the link is seen up again. final_gen is taken from cur_gen at that moment (2 when the partner moved up, 1 otherwise).
- R8: A link-up wait, whether the first one or the reconfirmation, that lasts LINK_TIMEOUT cycles ends in failure.
- R9: On failure, fail rises, ltssm_en drops, and phy_rx_reset_req is high for exactly RXRST_LEN consecutive cycles starting with the cycle fail rises.
- R10: done and fail are never both 1. Each holds until the next accepted start. A start while a bring-up is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up (accepted when idle, done or failed) |
| cfg_gen2 | input | 1 | Target rate: 1 allows the Gen2 speed change |
| cfg_no_chg_wait | input | 1 | Variant strap: skip the wait for the pending flag to clear |
| link_up | input | 1 | Link-up status bit from the link core |
| link_training | input | 1 | Training-in-progress status bit from the link core |
| chg_pending | input | 1 | Directed speed change still pending |
| cur_gen | input | 4 | Current negotiated generation from the link status |
| max_speed | output | 4 | Link-speed cap field driven to the core |
| ltssm_en | output | 1 | Training state machine enable |
| chg_req | output | 1 | One-cycle directed speed-change request |
| done | output | 1 | Bring-up succeeded (sticky) |
| fail | output | 1 | Bring-up failed (sticky) |
| final_gen | output | 4 | Generation latched at success |
| phy_rx_reset_req | output | 1 | PHY receive-reset request pulse |

## Verification
The bench models the link partner with configurable delays and random cases, and targets several corners.

- A pending flag that never clears must fail the normal variant, yet succeed at Gen1 under the skip strap. A design that ignored the strap would hang or fail there.
- A partner that drops the link during the speed change and never returns must hit the reconfirmation timeout rather than report done with a stale generation.
- Every bring-up checks that training enable rises a cycle after the cap write. An early enable would be visible as ltssm_en high on the first cycle after start.
- A start pulse in mid-training must not restart the sequence; a restart would show up as a momentary drop of ltssm_en.
- The length of the reset pulse and the single speed-change pulse are counted to catch off-by-one counters.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   localparam int unsigned GEN_FIELD_W = 4;

   localparam logic [GEN_FIELD_W-1:0] SPEED_GEN1 = GEN_FIELD_W'(1);
   localparam logic [GEN_FIELD_W-1:0] SPEED_GEN2 = GEN_FIELD_W'(2);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CAP,
      ST_TRAIN,
      ST_SPDWAIT,
      ST_RECHECK,
      ST_DONE,
      ST_FAILED
   } lsu_state_e;

endpackage

// File: rtl/lsu_wait_timer.sv
module lsu_wait_timer #(
   parameter int unsigned LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic expired
);
   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clr || !run)       cnt_q <= '0;
      else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q == LAST);

   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LAST);

endmodule

// File: rtl/lsu_chg_poller.sv
module lsu_chg_poller #(
   parameter int unsigned GAP   = 4,
   parameter int unsigned POLLS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   input  logic pending,
   output logic cleared,
   output logic gave_up
);
   localparam int unsigned GW = $clog2(GAP);
   localparam int unsigned PW = $clog2(POLLS) + 1;
   localparam logic [GW-1:0] GAP_LAST  = GW'(GAP - 1);
   localparam logic [PW-1:0] POLL_LAST = PW'(POLLS - 1);

   logic [GW-1:0] gcnt_q;
   logic [PW-1:0] pcnt_q;
   logic          poll_now;

   assign poll_now = run && (gcnt_q == GAP_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gcnt_q <= '0;
         pcnt_q <= '0;
      end else if (clr || !run) begin
         gcnt_q <= '0;
         pcnt_q <= '0;
      end else begin
         gcnt_q <= poll_now ? '0 : gcnt_q + 1'b1;
         if (poll_now) pcnt_q <= pcnt_q + 1'b1;
      end
   end

   assign cleared = poll_now && !pending;
   assign gave_up = poll_now && pending && (pcnt_q == POLL_LAST);

   // R5
   poll_count_chk: assert property (@(posedge clk) disable iff (!rst_n) pcnt_q <= POLL_LAST);

endmodule

// File: rtl/lsu_pulse_gen.sv
module lsu_pulse_gen #(
   parameter int unsigned LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic pulse
);
   generate
      if (LEN == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= trig;
         end
         assign pulse = q;
      end else begin : g_count
         localparam int unsigned CW = $clog2(LEN + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (trig)          cnt_q <= CW'(LEN);
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
         end
         assign pulse = (cnt_q != '0);
      end
   endgenerate

   // R9
   pulse_follows_trig_chk: assert property (@(posedge clk) disable iff (!rst_n) trig |=> pulse);

endmodule

// File: rtl/link_speedup_ctrl.sv
module link_speedup_ctrl
   import lsu_pkg::*;
#(
   parameter int unsigned LINK_TIMEOUT = 1250000,
   parameter int unsigned POLL_LIMIT   = 200,
   parameter int unsigned POLL_GAP     = 12500,
   parameter int unsigned RXRST_LEN    = 250
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   cfg_gen2,
   input  logic                   cfg_no_chg_wait,
   input  logic                   link_up,
   input  logic                   link_training,
   input  logic                   chg_pending,
   input  logic [GEN_FIELD_W-1:0] cur_gen,
   output logic [GEN_FIELD_W-1:0] max_speed,
   output logic                   ltssm_en,
   output logic                   chg_req,
   output logic                   done,
   output logic                   fail,
   output logic [GEN_FIELD_W-1:0] final_gen,
   output logic                   phy_rx_reset_req
);

   generate
      if (LINK_TIMEOUT < 2) begin : g_bad_timeout
         $error("LINK_TIMEOUT must be at least 2");
      end
      if (POLL_GAP < 2) begin : g_bad_gap
         $error("POLL_GAP must be at least 2");
      end
      if (POLL_LIMIT < 1) begin : g_bad_polls
         $error("POLL_LIMIT must be at least 1");
      end
      if (RXRST_LEN < 1) begin : g_bad_rxrst
         $error("RXRST_LEN must be at least 1");
      end
   endgenerate

   lsu_state_e state_q, state_d;
   logic       link_ok;
   logic       restartable;
   logic       wait_run, wait_expired;
   logic       poll_run, poll_cleared, poll_gave_up;
   logic       leaving;
   logic       fail_trig;

   assign link_ok     = link_up && !link_training;
   assign restartable = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAILED);
   assign wait_run    = (state_q == ST_TRAIN) || (state_q == ST_RECHECK);
   assign poll_run    = (state_q == ST_SPDWAIT);
   assign leaving     = (state_q != state_d);
   assign fail_trig   = (state_d == ST_FAILED) && (state_q != ST_FAILED);

   lsu_wait_timer #(.LIMIT(LINK_TIMEOUT)) u_link_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (wait_run),
      .clr     (leaving),
      .expired (wait_expired)
   );

   lsu_chg_poller #(.GAP(POLL_GAP), .POLLS(POLL_LIMIT)) u_poller (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (poll_run),
      .clr     (leaving),
      .pending (chg_pending),
      .cleared (poll_cleared),
      .gave_up (poll_gave_up)
   );

   lsu_pulse_gen #(.LEN(RXRST_LEN)) u_rx_reset (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (fail_trig),
      .pulse (phy_rx_reset_req)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE, ST_DONE, ST_FAILED: begin
            if (start) state_d = ST_CAP;
         end
         ST_CAP: state_d = ST_TRAIN;
         ST_TRAIN: begin
            if (link_ok) begin
               if (!cfg_gen2)            state_d = ST_DONE;
               else if (cfg_no_chg_wait) state_d = ST_RECHECK;
               else                      state_d = ST_SPDWAIT;
            end else if (wait_expired) begin
               state_d = ST_FAILED;
            end
         end
         ST_SPDWAIT: begin
            if (poll_cleared)      state_d = ST_RECHECK;
            else if (poll_gave_up) state_d = ST_FAILED;
         end
         ST_RECHECK: begin
            if (link_ok)           state_d = ST_DONE;
            else if (wait_expired) state_d = ST_FAILED;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         max_speed <= SPEED_GEN1;
         ltssm_en  <= 1'b0;
         chg_req   <= 1'b0;
         done      <= 1'b0;
         fail      <= 1'b0;
         final_gen <= '0;
      end else begin
         state_q <= state_d;
         done    <= (state_d == ST_DONE);
         fail    <= (state_d == ST_FAILED);
         chg_req <= (state_q == ST_TRAIN) && link_ok && cfg_gen2;

         if (restartable && start) begin
            max_speed <= SPEED_GEN1;
            ltssm_en  <= 1'b0;
            final_gen <= '0;
         end else if (state_q == ST_CAP) begin
            ltssm_en <= 1'b1;
         end else if ((state_q == ST_TRAIN) && link_ok && cfg_gen2) begin
            max_speed <= SPEED_GEN2;
         end

         if (fail_trig) ltssm_en <= 1'b0;

         if ((state_d == ST_DONE) && (state_q != ST_DONE)) final_gen <= cur_gen;
      end
   end

   // R2
   ltssm_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ltssm_en) |-> (max_speed == SPEED_GEN1) && ($past(max_speed) == SPEED_GEN1));

   // R4
   chg_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_req |=> !chg_req);

   // R4
   chg_req_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_req |-> (max_speed == SPEED_GEN2));

   // R3
   done_gen1_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && !cfg_gen2) |-> (max_speed == SPEED_GEN1));

   // R10
   done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

   // R9
   fail_drops_ltssm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> !ltssm_en);

   // R9
   rx_reset_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> phy_rx_reset_req);

endmodule

// File: tb/link_speedup_ctrl_test.sv
`timescale 1ns/1ps
module link_speedup_ctrl_test;

   localparam int unsigned T_LINK  = 64;
   localparam int unsigned T_POLLS = 8;
   localparam int unsigned T_GAP   = 4;
   localparam int unsigned T_RXRST = 5;
   localparam int          NEVER   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       cfg_gen2 = 1'b0;
   logic       cfg_no_chg_wait = 1'b0;
   logic       link_up = 1'b0;
   logic       link_training = 1'b0;
   logic       chg_pending = 1'b0;
   logic [3:0] cur_gen = '0;
   logic [3:0] max_speed;
   logic       ltssm_en, chg_req, done, fail, phy_rx_reset_req;
   logic [3:0] final_gen;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int n_chg = 0;
   int n_rst = 0;

   int p_up = 10, p_pend = 5, p_retr = 5;
   bit p_g2 = 1'b0;
   int ph = 0, pc = 0;

   always #4 clk = ~clk;

   link_speedup_ctrl #(
      .LINK_TIMEOUT (T_LINK),
      .POLL_LIMIT   (T_POLLS),
      .POLL_GAP     (T_GAP),
      .RXRST_LEN    (T_RXRST)
   ) uut (
      .clk              (clk),
      .rst_n            (rst_n),
      .start            (start),
      .cfg_gen2         (cfg_gen2),
      .cfg_no_chg_wait  (cfg_no_chg_wait),
      .link_up          (link_up),
      .link_training    (link_training),
      .chg_pending      (chg_pending),
      .cur_gen          (cur_gen),
      .max_speed        (max_speed),
      .ltssm_en         (ltssm_en),
      .chg_req          (chg_req),
      .done             (done),
      .fail             (fail),
      .final_gen        (final_gen),
      .phy_rx_reset_req (phy_rx_reset_req)
   );

   // link partner model
   always @(negedge clk) begin
      if (!rst_n || !ltssm_en) begin
         link_up = 1'b0; link_training = 1'b0; chg_pending = 1'b0;
         cur_gen = 4'd0; ph = 0; pc = 0;
      end else begin
         case (ph)
            0: begin
               link_training = 1'b1;
               pc++;
               if (p_up != NEVER && pc >= p_up) begin
                  link_up = 1'b1; link_training = 1'b0; cur_gen = 4'd1; ph = 1;
               end
            end
            1: if (chg_req) begin chg_pending = 1'b1; pc = 0; ph = 2; end
            2: begin
               pc++;
               if (p_pend != NEVER && pc >= p_pend) begin
                  chg_pending = 1'b0; link_up = 1'b0; link_training = 1'b1;
                  if (max_speed == 4'd2 && p_g2) cur_gen = 4'd2;
                  pc = 0; ph = 3;
               end
            end
            3: begin
               pc++;
               if (p_retr != NEVER && pc >= p_retr) begin
                  link_up = 1'b1; link_training = 1'b0; ph = 4;
               end
            end
            default: ;
         endcase
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++; bad++;
         $display("FAIL R8 watchdog act=%0d exp<=%0d", cyc, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (chg_req) n_chg++;
      if (phy_rx_reset_req) n_rst++;
   endtask

   function automatic void predict(input bit g2, input bit skip, input int up, input int pend,
                                   input int retr, input bit pg2,
                                   output bit ok, output int gen, output int mx, output int nchg);
      ok = 1'b0; gen = 0; mx = 1; nchg = 0;
      if (up == NEVER) return;
      if (!g2) begin ok = 1'b1; gen = 1; return; end
      mx = 2; nchg = 1;
      if (skip) begin ok = 1'b1; gen = 1; return; end
      if (pend == NEVER || retr == NEVER) return;
      ok = 1'b1; gen = pg2 ? 2 : 1;
   endfunction

   task automatic run_case(input bit g2, input bit skip, input int up, input int pend,
                           input int retr, input bit pg2, input bit poke);
      bit ok; int gen, mx, nchg;
      predict(g2, skip, up, pend, retr, pg2, ok, gen, mx, nchg);
      @(negedge clk);
      p_up = up; p_pend = pend; p_retr = retr; p_g2 = pg2;
      cfg_gen2 = g2; cfg_no_chg_wait = skip;
      start = 1'b1;
      n_chg = 0; n_rst = 0;
      tick();
      start = 1'b0;
      chk("R2 ltssm_en low after start", int'(ltssm_en), 0);
      chk("R2 cap forced to 1", int'(max_speed), 1);
      tick();
      chk("R2 ltssm_en high one cycle later", int'(ltssm_en), 1);
      if (poke) begin
         repeat (5) tick();
         start = 1'b1;
         tick();
         start = 1'b0;
         chk("R10 busy start ignored, ltssm_en kept", int'(ltssm_en), 1);
      end
      for (int i = 0; i < 3000 && !(done || fail); i++) tick();
      repeat (12) tick();
      chk("R3/R7 done", int'(done), int'(ok));
      chk("R10 fail vs done", int'(fail), int'(!ok));
      chk("R7 final_gen", int'(final_gen), gen);
      chk("R4 max_speed", int'(max_speed), mx);
      chk("R4 chg_req pulses", n_chg, nchg);
      chk("R9 rx reset length", n_rst, ok ? 0 : int'(T_RXRST));
      chk("R9 ltssm_en after end", int'(ltssm_en), int'(ok));
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      chk("R1 max_speed", int'(max_speed), 1);
      chk("R1 ltssm_en", int'(ltssm_en), 0);
      chk("R1 flags", int'({chg_req, done, fail, phy_rx_reset_req}), 0);
      chk("R1 final_gen", int'(final_gen), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle after release", int'({ltssm_en, done, fail}), 0);

      run_case(1'b0, 1'b0, 10, 5, 5, 1'b1, 1'b0);       // R3 Gen1 only
      run_case(1'b1, 1'b0, 8, 6, 12, 1'b1, 1'b0);       // R4 R5 R7 Gen2 reached
      run_case(1'b1, 1'b0, 8, 6, 12, 1'b0, 1'b0);       // R7 partner stays Gen1
      run_case(1'b1, 1'b1, 8, NEVER, 5, 1'b1, 1'b0);    // R6 skip, flag stuck
      run_case(1'b1, 1'b0, 8, NEVER, 5, 1'b1, 1'b0);    // R5 poll give-up
      run_case(1'b0, 1'b0, NEVER, 5, 5, 1'b0, 1'b0);    // R8 first wait timeout
      run_case(1'b1, 1'b0, 8, 6, NEVER, 1'b1, 1'b0);    // R8 reconfirm timeout
      run_case(1'b0, 1'b0, 30, 5, 5, 1'b0, 1'b1);       // R10 busy start
      run_case(1'b1, 1'b0, 1, 1, 1, 1'b1, 1'b0);        // shortest delays

      for (int k = 0; k < 40; k++) begin
         bit g2, skip, pg2;
         int up, pend, retr;
         g2   = $urandom % 2;
         skip = ($urandom % 3) == 0;
         pg2  = $urandom % 2;
         up   = (($urandom % 8) == 0) ? NEVER : 1 + int'($urandom % 40);
         pend = (($urandom % 6) == 0) ? NEVER : 1 + int'($urandom % 20);
         retr = (($urandom % 6) == 0) ? NEVER : 1 + int'($urandom % 40);
         run_case(g2, skip, up, pend, retr, pg2, 1'b0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule